// File: doc/BRIEF.md
# Binary32 Compare Flag Generator

This block compares two single-precision floating-point words, a left operand `d` and a right operand `m`, and returns the ordering as a four-bit condition code with an invalid-operation flag. It works directly on the packed bit patterns and never splits them into sign, exponent and fraction arithmetic. Equal words and zeros of opposite sign compare equal. When the signs differ, the negative word is the smaller one. When the signs match, the words are ordered as unsigned integers, and the outcome is inverted when both are negative.

A two-bit operation code picks one of four variants. Bit 0 selects signalling behaviour, so that a quiet NaN also raises invalid. Bit 1 replaces `m` with the all-zero word (+0). A request enters on a valid/ready handshake and is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is held in a one-deep output register and offered on `out_valid`/`out_ready`. A result stays unchanged while `out_ready` is low. `in_ready` is high whenever the register is empty or is being drained in the same cycle, so a new request can be accepted every cycle when the consumer never stalls.

Top module: `fcmp_flags_unit`

## Requirements
- R1: When neither operand is a NaN and the words are identical, the result code `{N,Z,C,V}` is 4'b0110 and invalid is 0.
- R2: When `d` orders below `m`, the result code is 4'b1000 (N only). This includes a negative `d` against a non-negative `m`.
- R3: When `d` orders above `m`, the result code is 4'b0010 (C only). An infinity (exponent 255, fraction 0) is ordered as a number.
- R4: An operand with exponent field bits[30:23] = 255 and a nonzero fraction bits[22:0] is a NaN. Any NaN operand makes the result unordered, 4'b0011.
- R5: With op bit 0 clear (quiet compare), invalid is set only for a NaN whose fraction bit 22 is 0. A NaN with bit 22 set leaves invalid at 0.
- R6: With op bit 0 set (signalling compare), every NaN operand sets invalid. Invalid is never set unless the code is unordered.
- R7: +0 (32'h00000000) and -0 (32'h80000000) compare equal in either order.
- R8: When both operands are negative, the ordering of the raw words is reversed. For example, 32'hC0000000 (-2) is below 32'hBF800000 (-1).
- R9: With op bit 1 set, `m` has no effect and `d` is compared against +0. A NaN on `m` then neither makes the result unordered nor raises invalid.
- R10: A request is accepted when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high in the following cycle and holds, unchanged, while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R11: While `rst_n` is low, and right after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 2 | Bit 0: signalling; bit 1: compare against +0 |
| in_d | input | 32 | Left operand, binary32 |
| in_m | input | 32 | Right operand, binary32 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result this cycle |
| out_nzcv | output | 4 | Condition code {N,Z,C,V} |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions assume that the inputs carry known values after reset. They also assume that reset is released away from a rising edge, since the stall check compares a held result with its value one cycle earlier. The stimulus changes inputs only on falling edges. It holds a request steady until it is accepted. It toggles `out_ready` in a fixed pattern, so that results are both stalled and drained back-to-back while the scoreboard tracks acceptance order.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int CODE_W = 4;
  localparam int RES_W  = CODE_W + 1;

  // position of the signal-on-quiet and zero-substitute bits in the op code
  localparam int OP_SIG_BIT  = 0;
  localparam int OP_ZERO_BIT = 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [CODE_W-1:0] nzcv;
    logic              invalid;
  } cmp_res_t;

  localparam logic [CODE_W-1:0] CODE_EQ  = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_LT  = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_GT  = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_UNO = 4'b0011;
endpackage

// File: rtl/fcmp_nan_detect.sv
module fcmp_nan_detect
  import fcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0] word,
  input  logic           sig_on_quiet,
  output logic           is_nan,
  output logic           raises_inv
);
  localparam logic [EW-1:0] EXP_ALL1 = '1;

  logic [EW-1:0] expf;
  logic [FW-1:0] frac;

  assign expf = word[EW+FW-1:FW];
  assign frac = word[FW-1:0];

  always_comb begin
    is_nan     = (expf == EXP_ALL1) && (frac != '0);
    raises_inv = is_nan && (sig_on_quiet || !frac[FW-1]);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         is_eq,
  output logic         is_lt,
  output logic         is_gt
);
  logic [W-2:0] mag_or;
  logic         sl, sr;
  logic         raw_lt;

  assign mag_or = lhs[W-2:0] | rhs[W-2:0];
  assign sl     = lhs[W-1];
  assign sr     = rhs[W-1];
  assign raw_lt = lhs < rhs;

  always_comb begin
    is_eq = 1'b0;
    is_lt = 1'b0;
    is_gt = 1'b0;
    if (lhs == rhs || mag_or == '0) begin
      is_eq = 1'b1;
    end else if (sl != sr) begin
      is_lt = sl;
      is_gt = !sl;
    end else begin
      // same sign: raw integer order, flipped for negatives
      is_lt = raw_lt ^ sl;
      is_gt = !(raw_lt ^ sl);
    end
  end
endmodule

// File: rtl/fcmp_out_stage.sv
module fcmp_out_stage #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [PW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [PW-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);

  // R11
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> !dn_valid);
endmodule

// File: rtl/fcmp_flags_unit.sv
module fcmp_flags_unit
  import fcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [WORD_W-1:0] in_d,
  input  logic [WORD_W-1:0] in_m,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_nzcv,
  output logic              out_invalid
);
  localparam int NOPS = 2;

  word_t    opnd [NOPS];
  logic     nan_v [NOPS];
  logic     inv_v [NOPS];
  logic     eq, lt, gt;
  logic     any_nan, any_inv;
  cmp_res_t res_next, res_q;

  assign opnd[0] = in_d;
  assign opnd[1] = in_op[OP_ZERO_BIT] ? '0 : in_m;

  for (genvar i = 0; i < NOPS; i++) begin : g_nan
    fcmp_nan_detect #(.EW(EXP_W), .FW(FRAC_W)) u_det (
      .word        (opnd[i]),
      .sig_on_quiet(in_op[OP_SIG_BIT]),
      .is_nan      (nan_v[i]),
      .raises_inv  (inv_v[i])
    );
  end

  fcmp_order #(.W(WORD_W)) u_ord (
    .lhs  (opnd[0]),
    .rhs  (opnd[1]),
    .is_eq(eq),
    .is_lt(lt),
    .is_gt(gt)
  );

  always_comb begin
    any_nan = nan_v[0] || nan_v[1];
    any_inv = inv_v[0] || inv_v[1];
    res_next.invalid = any_inv;
    if (any_nan)   res_next.nzcv = CODE_UNO;
    else if (eq)   res_next.nzcv = CODE_EQ;
    else if (lt)   res_next.nzcv = CODE_LT;
    else if (gt)   res_next.nzcv = CODE_GT;
    else           res_next.nzcv = CODE_UNO;
  end

  fcmp_out_stage #(.PW(RES_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (res_next),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (res_q)
  );

  assign out_nzcv    = res_q.nzcv;
  assign out_invalid = res_q.invalid;

  // R1
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nzcv == CODE_EQ || out_nzcv == CODE_LT ||
                   out_nzcv == CODE_GT || out_nzcv == CODE_UNO));

  // R6
  inv_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_nzcv == CODE_UNO);

  // R4
  nan_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_d[WORD_W-2:FRAC_W] == '1) &&
    (in_d[FRAC_W-1:0] != '0) |=> out_valid && out_nzcv == CODE_UNO);

  // R9
  zero_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[OP_ZERO_BIT] && (in_d[WORD_W-2:0] == '0)
    |=> out_nzcv == CODE_EQ && !out_invalid);
endmodule

// File: tb/fcmp_flags_unit_test.sv
`timescale 1ns/1ps
module fcmp_flags_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [31:0] in_d = '0;
  logic [31:0] in_m = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_nzcv;
  logic        out_invalid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;
  int rcnt = 0;

  typedef struct {
    logic [4:0] exp_res;
    string      tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  fcmp_flags_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_d(in_d), .in_m(in_m), .out_valid(out_valid),
    .out_ready(out_ready), .out_nzcv(out_nzcv), .out_invalid(out_invalid)
  );

  function automatic bit nan_of(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  // reference: signed-magnitude key ordering
  function automatic logic [4:0] model(input logic [1:0] op,
                                       input logic [31:0] d,
                                       input logic [31:0] m);
    logic [31:0] mm;
    logic signed [32:0] kd, km;
    bit inv;
    mm = op[1] ? 32'h0 : m;
    if (nan_of(d) || nan_of(mm)) begin
      inv = (nan_of(d) && (op[0] || !d[22])) || (nan_of(mm) && (op[0] || !mm[22]));
      return {4'b0011, inv};
    end
    kd = d[31] ? -$signed({2'b0, d[30:0]}) : $signed({2'b0, d[30:0]});
    km = mm[31] ? -$signed({2'b0, mm[30:0]}) : $signed({2'b0, mm[30:0]});
    if (kd == km) return {4'b0110, 1'b0};
    if (kd < km)  return {4'b1000, 1'b0};
    return {4'b0010, 1'b0};
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic send(input logic [1:0] op, input logic [31:0] d,
                      input logic [31:0] m, input string tag);
    item_t it;
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_d = d; in_m = m;
      #1;
      checks++;
      if (in_ready !== (!out_valid || out_ready))
        fail_line("R10", "in_ready", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
      acc = in_ready;
    end
    it.exp_res = model(op, d, m);
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer readiness
  initial begin
    forever begin
      @(negedge clk);
      rcnt++;
      out_ready = stall_mode ? ((rcnt % 3) == 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit pv, pr;
    logic [4:0] pdat;
    item_t it;
    pv = 1'b0; pr = 1'b1; pdat = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (pv && !pr) begin
          checks++;
          if (!out_valid || {out_nzcv, out_invalid} !== pdat)
            fail_line("R10", "stall hold", {26'd0, out_valid, out_nzcv, out_invalid},
                      {26'd0, 1'b1, pdat});
        end
        if (out_valid && out_ready) begin
          checks++;
          if (sb.size() == 0) begin
            fail_line("R10", "unexpected result", {27'd0, out_nzcv, out_invalid}, 32'd0);
          end else begin
            it = sb.pop_front();
            if ({out_nzcv, out_invalid} !== it.exp_res)
              fail_line(it.tag, "nzcv,inv", {27'd0, out_nzcv, out_invalid},
                        {27'd0, it.exp_res});
          end
        end
        pv = out_valid; pr = out_ready; pdat = {out_nzcv, out_invalid};
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) fail_line("R11", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) fail_line("R11", "out_valid after reset", {31'd0, out_valid}, 32'd0);

    send(2'b00, 32'h3F800000, 32'h3F800000, "R1");
    send(2'b00, 32'h00000000, 32'h80000000, "R7");
    send(2'b00, 32'h80000000, 32'h00000000, "R7");
    send(2'b00, 32'h3F800000, 32'h40000000, "R2");
    send(2'b00, 32'hBF800000, 32'h3F800000, "R2");
    send(2'b00, 32'h40000000, 32'h3F800000, "R3");
    send(2'b00, 32'h7F800000, 32'h3F800000, "R3");
    send(2'b00, 32'h00000001, 32'h80000000, "R3");
    send(2'b00, 32'hC0000000, 32'hBF800000, "R8");
    send(2'b00, 32'hBF800000, 32'hC0000000, "R8");
    send(2'b00, 32'h7FC00000, 32'h3F800000, "R4");
    send(2'b00, 32'h3F800000, 32'hFFC00001, "R4");
    send(2'b00, 32'h7F800001, 32'h3F800000, "R5");
    send(2'b00, 32'h3F800000, 32'h7FA00000, "R5");
    send(2'b01, 32'h7FC00000, 32'h3F800000, "R6");
    send(2'b01, 32'h3F800000, 32'h3F800000, "R6");
    send(2'b10, 32'hBF800000, 32'h7F800001, "R9");
    send(2'b10, 32'h80000000, 32'h3F800000, "R9");
    send(2'b10, 32'h3F800000, 32'hFF800000, "R9");
    send(2'b11, 32'h7FC00000, 32'h00000000, "R9");

    stall_mode = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      a = 32'h3F800000 + (i * 32'h00700000);
      b = (i % 2) ? 32'hC0400000 : 32'h40400000;
      send(2'(i % 4), (i % 5 == 0) ? (a | 32'h80000000) : a, b, "R10");
    end
    stall_mode = 1'b0;

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule